// File: doc/BRIEF.md
# Configurable Registered Logic Macrocell

This block is one output cell of a small sum-of-products logic device. It takes eight product terms from the array and one extra term that serves as either a clock or an output enable. From these it produces a pad drive value, a pad enable and a feedback bit that goes back into the array. Static configuration inputs choose the operating mode:

- combinatorial or registered
- the flip-flop kind: D, T, J-K or S-R
- how the eight terms are shared between the J and K paths
- the polarity of each flip-flop input and of the output
- whether the register is clocked by the bank clock pin or by the clock/enable term
- whether feedback is taken from the register or from the pin

The cell runs on a fabric clock `clk`. The bank clock pin and the clock/enable term are treated as slow signals and sampled on `clk`. A rising level on the selected clock source becomes a one-cycle update strobe. A synchronous preload forces any register value for test. The register clears on power-up reset.

Top module: `sopmc_macrocell`

## Requirements
- R1: While `rst_n` is low, and after its release until the first update, the register holds 0. In registered mode `pad_out` then equals `cfg_out_inv`.
- R2: With `cfg_reg`=0, `pad_out` = (OR of `pterm`) XOR `cfg_out_inv` in the same cycle, `pad_oe` follows `ctl_pt`, and `fb` equals `pad_in`.
- R3: With kind 2'b00 (D), the register takes (OR of `pterm`) XOR `cfg_pol_a`. It updates on the first `clk` rising edge that samples the selected clock source high after it was sampled low.
- R4: With kind 2'b01 (T), an update inverts the register when (OR of `pterm`) XOR `cfg_pol_a` is 1, and keeps it otherwise.
- R5: With kind 2'b10 (J-K), J is (OR of `pterm[N-1:0]`) XOR `cfg_pol_a` and K is (OR of the remaining terms) XOR `cfg_pol_b`, where N = `cfg_split`. On an update, JK = 00 holds, 01 clears, 10 sets and 11 toggles.
- R6: For split N=0, J gets no terms and equals `cfg_pol_a`. For N=8, K gets no terms and equals `cfg_pol_b`.
- R7: With kind 2'b11 (S-R), S uses the J path and R uses the K path. On an update, SR = 10 sets, 01 clears and 00 holds. The case where both are 1 is not specified.
- R8: In registered mode with `cfg_async`=0, only a rise of `bank_clk` causes an update, and `pad_oe` equals `ctl_pt`.
- R9: In registered mode with `cfg_async`=1, only a rise of `ctl_pt` causes an update, and `pad_oe` is held at 1.
- R10: In registered D or T mode, `fb` is `pad_in` when `cfg_fb_pin`=1 and the register otherwise. In J-K and S-R modes, `fb` is always the register, whatever `cfg_fb_pin` is.
- R11: When `preload_en` is sampled high at a `clk` edge, the register takes `preload_val`, even if an update occurs at the same edge.
- R12: In registered mode, `pad_out` equals the register XOR `cfg_out_inv`.
- R13: The register does not change in a cycle with neither an update nor a preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples everything |
| rst_n | input | 1 | Power-up reset, active low, asserted asynchronously |
| bank_clk | input | 1 | Bank clock pin level |
| ctl_pt | input | 1 | Clock/enable product term |
| pterm | input | 8 | Product terms from the array |
| cfg_reg | input | 1 | 1 = registered, 0 = combinatorial |
| cfg_ff_kind | input | 2 | 00 D, 01 T, 10 J-K, 11 S-R |
| cfg_split | input | 4 | Number of low terms routed to J (0..8) |
| cfg_pol_a | input | 1 | Inversion of D/T/J/S input |
| cfg_pol_b | input | 1 | Inversion of K/R input |
| cfg_out_inv | input | 1 | Output inversion |
| cfg_async | input | 1 | 1 = clock from `ctl_pt` |
| cfg_fb_pin | input | 1 | 1 = feedback from pin (D/T only) |
| preload_en | input | 1 | Synchronous register force |
| preload_val | input | 1 | Value forced by preload |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad drive enable |
| fb | output | 1 | Feedback bit to the array |

## Verification
The bench tests the J/K split at its ends (N=0 and N=8). A design that routes the wrong bit range, or that ORs in a phantom term, would set or clear the register when it should not. It checks that the clock source not selected is ignored, and that the enable rule switches in asynchronous mode. A swapped clock mux would capture on the wrong pulse or leave the pad floating. It drives a preload in the same cycle as an update, which catches the wrong priority. It also checks that J-K and S-R feedback ignores the pin-feedback bit; a design that shares the D/T feedback mux would fail there.

// File: rtl/sopmc_pkg.sv
package sopmc_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'b00,
    FF_T  = 2'b01,
    FF_JK = 2'b10,
    FF_SR = 2'b11
  } ff_kind_e;
endpackage

// File: rtl/sopmc_term_route.sv
module sopmc_term_route #(
  parameter int NPT     = 8,
  parameter int SPLIT_W = $clog2(NPT + 1)
) (
  input  logic [NPT-1:0]     pterm,
  input  logic [SPLIT_W-1:0] split,
  input  logic               pol_a,
  input  logic               pol_b,
  output logic               sum_raw,
  output logic               d_eff,
  output logic               j_eff,
  output logic               k_eff
);
  logic [NPT-1:0] to_j;

  // Terms below the split index go to J, the rest go to K.
  for (genvar g = 0; g < NPT; g++) begin : g_mask
    assign to_j[g] = (SPLIT_W'(g) < split);
  end

  assign sum_raw = |pterm;
  assign d_eff   = sum_raw ^ pol_a;
  assign j_eff   = (|(pterm & to_j)) ^ pol_a;
  assign k_eff   = (|(pterm & ~to_j)) ^ pol_b;
endmodule

// File: rtl/sopmc_clk_sel.sv
module sopmc_clk_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic bank_clk,
  input  logic ctl_pt,
  input  logic reg_mode,
  input  logic async_mode,
  output logic tick,
  output logic oe
);
  logic src;
  logic src_q;

  assign src = async_mode ? ctl_pt : bank_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign tick = src & ~src_q;
  // The product term is a clock in asynchronous registered mode, otherwise an enable.
  assign oe   = (reg_mode && async_mode) ? 1'b1 : ctl_pt;
endmodule

// File: rtl/sopmc_state_reg.sv
module sopmc_state_reg
  import sopmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  ff_kind_e kind,
  input  logic     d_eff,
  input  logic     j_eff,
  input  logic     k_eff,
  input  logic     preload_en,
  input  logic     preload_val,
  output logic     q
);
  logic q_upd;
  logic q_nxt;

  always_comb begin
    unique case (kind)
      FF_D:  q_upd = d_eff;
      FF_T:  q_upd = q ^ d_eff;
      FF_JK: begin
        unique case ({j_eff, k_eff})
          2'b00:   q_upd = q;
          2'b01:   q_upd = 1'b0;
          2'b10:   q_upd = 1'b1;
          default: q_upd = ~q;
        endcase
      end
      default: begin
        unique case ({j_eff, k_eff})
          2'b01:   q_upd = 1'b0;
          2'b10:   q_upd = 1'b1;
          default: q_upd = q;
        endcase
      end
    endcase
  end

  always_comb begin
    if (preload_en) q_nxt = preload_val;
    else if (tick)  q_nxt = q_upd;
    else            q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/sopmc_macrocell.sv
module sopmc_macrocell
  import sopmc_pkg::*;
#(
  parameter int NPT        = 8,
  parameter int SPLIT_W    = $clog2(NPT + 1),
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bank_clk,
  input  logic               ctl_pt,
  input  logic [NPT-1:0]     pterm,
  input  logic               cfg_reg,
  input  logic [1:0]         cfg_ff_kind,
  input  logic [SPLIT_W-1:0] cfg_split,
  input  logic               cfg_pol_a,
  input  logic               cfg_pol_b,
  input  logic               cfg_out_inv,
  input  logic               cfg_async,
  input  logic               cfg_fb_pin,
  input  logic               preload_en,
  input  logic               preload_val,
  input  logic               pad_in,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               fb
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;
  logic                  sum_raw, d_eff, j_eff, k_eff;
  logic                  tick;
  logic                  state_q;
  ff_kind_e              kind;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  assign kind = ff_kind_e'(cfg_ff_kind);

  sopmc_term_route #(.NPT(NPT), .SPLIT_W(SPLIT_W)) u_route (
    .pterm   (pterm),
    .split   (cfg_split),
    .pol_a   (cfg_pol_a),
    .pol_b   (cfg_pol_b),
    .sum_raw (sum_raw),
    .d_eff   (d_eff),
    .j_eff   (j_eff),
    .k_eff   (k_eff)
  );

  sopmc_clk_sel u_clk (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bank_clk   (bank_clk),
    .ctl_pt     (ctl_pt),
    .reg_mode   (cfg_reg),
    .async_mode (cfg_async),
    .tick       (tick),
    .oe         (pad_oe)
  );

  sopmc_state_reg u_state (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick        (tick),
    .kind        (kind),
    .d_eff       (d_eff),
    .j_eff       (j_eff),
    .k_eff       (k_eff),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .q           (state_q)
  );

  assign pad_out = (cfg_reg ? state_q : sum_raw) ^ cfg_out_inv;

  always_comb begin
    if (!cfg_reg)                                      fb = pad_in;
    else if (cfg_fb_pin && (kind == FF_D || kind == FF_T)) fb = pad_in;
    else                                               fb = state_q;
  end
endmodule

// File: rtl/sopmc_checker.sv
module sopmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bank_clk,
  input logic       ctl_pt,
  input logic       cfg_reg,
  input logic [1:0] cfg_ff_kind,
  input logic       cfg_async,
  input logic       cfg_fb_pin,
  input logic       cfg_out_inv,
  input logic       preload_en,
  input logic       preload_val,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       fb,
  input logic       state_q
);
  logic src_chk;
  assign src_chk = cfg_async ? ctl_pt : bank_clk;

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |-> state_q == 1'b0);

  assert_preload_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> state_q == $past(preload_val));

  assert_hold_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && !$rose(src_chk)) |=> $stable(state_q));

  assert_async_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg && cfg_async) |-> pad_oe);

  assert_sync_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_reg && cfg_async) |-> pad_oe == ctl_pt);

  assert_jk_fb_q_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg && cfg_ff_kind[1]) |-> fb == state_q);

  assert_out_pol_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reg |-> (pad_out ^ state_q) == cfg_out_inv);
endmodule

bind sopmc_macrocell sopmc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bank_clk    (bank_clk),
  .ctl_pt      (ctl_pt),
  .cfg_reg     (cfg_reg),
  .cfg_ff_kind (cfg_ff_kind),
  .cfg_async   (cfg_async),
  .cfg_fb_pin  (cfg_fb_pin),
  .cfg_out_inv (cfg_out_inv),
  .preload_en  (preload_en),
  .preload_val (preload_val),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .fb          (fb),
  .state_q     (state_q)
);

// File: tb/sim_sopmc_macrocell.sv
`timescale 1ns/1ps
module sim_sopmc_macrocell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       bank_clk = 1'b0, ctl_pt = 1'b0;
  logic [7:0] pterm = '0;
  logic       cfg_reg = 1'b1;
  logic [1:0] cfg_ff_kind = 2'b00;
  logic [3:0] cfg_split = 4'd0;
  logic       cfg_pol_a = 1'b0, cfg_pol_b = 1'b0, cfg_out_inv = 1'b0;
  logic       cfg_async = 1'b0, cfg_fb_pin = 1'b0;
  logic       preload_en = 1'b0, preload_val = 1'b0, pad_in = 1'b0;
  logic       pad_out, pad_oe, fb;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sopmc_macrocell u0 (
    .clk(clk), .rst_n(rst_n), .bank_clk(bank_clk), .ctl_pt(ctl_pt), .pterm(pterm),
    .cfg_reg(cfg_reg), .cfg_ff_kind(cfg_ff_kind), .cfg_split(cfg_split),
    .cfg_pol_a(cfg_pol_a), .cfg_pol_b(cfg_pol_b), .cfg_out_inv(cfg_out_inv),
    .cfg_async(cfg_async), .cfg_fb_pin(cfg_fb_pin), .preload_en(preload_en),
    .preload_val(preload_val), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .fb(fb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_bank();
    bank_clk = 1'b1; cyc();
    bank_clk = 1'b0; cyc();
  endtask

  task automatic pulse_ctl();
    ctl_pt = 1'b1; cyc();
    ctl_pt = 1'b0; cyc();
  endtask

  task automatic force_q(input logic v);
    preload_en = 1'b1; preload_val = v; cyc();
    preload_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc();
    cfg_reg = 1'b1; cfg_out_inv = 1'b1; #1;
    chk("R1 reset pad", pad_out, 1'b1);
    chk("R1 reset fb", fb, 1'b0);
    rst_n = 1'b1; repeat (3) cyc();
    chk("R1 after release", fb, 1'b0);
    cfg_out_inv = 1'b0;
  endtask

  task automatic t_comb();
    cfg_reg = 1'b0; pterm = 8'h00; cfg_out_inv = 1'b0; #1;
    chk("R2 comb zero", pad_out, 1'b0);
    pterm = 8'h10; #1;
    chk("R2 comb one", pad_out, 1'b1);
    cfg_out_inv = 1'b1; #1;
    chk("R2 comb inv", pad_out, 1'b0);
    ctl_pt = 1'b1; #1; chk("R2 oe on", pad_oe, 1'b1);
    ctl_pt = 1'b0; #1; chk("R2 oe off", pad_oe, 1'b0);
    pad_in = 1'b1; #1; chk("R2 fb pin", fb, 1'b1);
    pad_in = 1'b0; cfg_out_inv = 1'b0; cfg_reg = 1'b1; pterm = '0; cyc();
  endtask

  task automatic t_dmode();
    cfg_ff_kind = 2'b00; cfg_pol_a = 1'b0; force_q(1'b0);
    pterm = 8'h01; pulse_bank(); chk("R3 d set", fb, 1'b1);
    pterm = 8'h00; cyc(); cyc(); chk("R13 hold no edge", fb, 1'b1);
    cfg_out_inv = 1'b1; #1; chk("R12 out inv", pad_out, 1'b0);
    cfg_out_inv = 1'b0;
    pulse_bank(); chk("R3 d clear", fb, 1'b0);
    cfg_pol_a = 1'b1; pterm = 8'h80; pulse_bank(); chk("R3 d pol", fb, 1'b0);
    pterm = 8'h00; pulse_bank(); chk("R3 d pol zero", fb, 1'b1);
    cfg_pol_a = 1'b0;
  endtask

  task automatic t_tmode();
    cfg_ff_kind = 2'b01; force_q(1'b0);
    pterm = 8'h20; pulse_bank(); chk("R4 toggle up", fb, 1'b1);
    pulse_bank(); chk("R4 toggle down", fb, 1'b0);
    pterm = 8'h00; pulse_bank(); chk("R4 hold", fb, 1'b0);
  endtask

  task automatic t_jk();
    cfg_ff_kind = 2'b10; cfg_split = 4'd3; force_q(1'b0);
    pterm = 8'h04; pulse_bank(); chk("R5 jk set", fb, 1'b1);
    pterm = 8'h00; pulse_bank(); chk("R5 jk hold", fb, 1'b1);
    pterm = 8'h08; pulse_bank(); chk("R5 jk clear", fb, 1'b0);
    pterm = 8'h0C; pulse_bank(); chk("R5 jk toggle1", fb, 1'b1);
    pulse_bank(); chk("R5 jk toggle2", fb, 1'b0);
    cfg_pol_b = 1'b1; force_q(1'b1); pterm = 8'h00;
    pulse_bank(); chk("R5 k polarity", fb, 1'b0);
    cfg_pol_b = 1'b0;
    cfg_split = 4'd0; force_q(1'b1); pterm = 8'h01;
    pulse_bank(); chk("R6 n0 all to k", fb, 1'b0);
    cfg_pol_a = 1'b1; pterm = 8'h00;
    pulse_bank(); chk("R6 n0 j from pol", fb, 1'b1);
    cfg_pol_a = 1'b0;
    cfg_split = 4'd8; force_q(1'b0); pterm = 8'h80;
    pulse_bank(); chk("R6 n8 all to j", fb, 1'b1);
  endtask

  task automatic t_sr();
    cfg_ff_kind = 2'b11; cfg_split = 4'd4; force_q(1'b0);
    pterm = 8'h01; pulse_bank(); chk("R7 sr set", fb, 1'b1);
    pterm = 8'h00; pulse_bank(); chk("R7 sr hold", fb, 1'b1);
    pterm = 8'h10; pulse_bank(); chk("R7 sr reset", fb, 1'b0);
    cfg_fb_pin = 1'b1; pad_in = 1'b1; #1;
    chk("R10 sr ignores pin fb", fb, 1'b0);
    cfg_fb_pin = 1'b0; pad_in = 1'b0;
  endtask

  task automatic t_clocks();
    cfg_ff_kind = 2'b00; cfg_async = 1'b0; force_q(1'b0);
    ctl_pt = 1'b1; #1; chk("R8 sync oe high", pad_oe, 1'b1);
    ctl_pt = 1'b0; #1; chk("R8 sync oe low", pad_oe, 1'b0);
    pterm = 8'h01; pulse_ctl(); chk("R8 ctl ignored", fb, 1'b0);
    pulse_bank(); chk("R8 bank clocks", fb, 1'b1);
    cfg_async = 1'b1; force_q(1'b0); #1;
    chk("R9 async oe", pad_oe, 1'b1);
    pulse_bank(); chk("R9 bank ignored", fb, 1'b0);
    pulse_ctl(); chk("R9 ctl clocks", fb, 1'b1);
    cfg_async = 1'b0; pterm = 8'h00;
  endtask

  task automatic t_feedback();
    cfg_ff_kind = 2'b00; force_q(1'b0);
    cfg_fb_pin = 1'b1; pad_in = 1'b1; #1;
    chk("R10 d pin fb", fb, 1'b1);
    cfg_ff_kind = 2'b10; #1;
    chk("R10 jk q fb", fb, 1'b0);
    cfg_ff_kind = 2'b01; #1;
    chk("R10 t pin fb", fb, 1'b1);
    cfg_fb_pin = 1'b0; #1;
    chk("R10 t q fb", fb, 1'b0);
    pad_in = 1'b0; cfg_ff_kind = 2'b00;
  endtask

  task automatic t_preload();
    cfg_ff_kind = 2'b00; force_q(1'b0); pterm = 8'h00;
    preload_en = 1'b1; preload_val = 1'b1; bank_clk = 1'b1; cyc();
    preload_en = 1'b0; #1;
    chk("R11 preload beats edge", fb, 1'b1);
    bank_clk = 1'b0; cyc();
    force_q(1'b0); #1;
    chk("R11 preload zero", fb, 1'b0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_comb();
    t_dmode();
    t_tmode();
    t_jk();
    t_sr();
    t_clocks();
    t_feedback();
    t_preload();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule